// File: doc/BRIEF.md
# Configuration Address/Data Port Dispatcher

This block sits behind a host I/O bus and implements a two-port configuration mechanism. One port is a 32-bit address latch written and read as a whole dword. The other is a four-byte data window whose accesses are steered to one of `NSLOT` downstream configuration targets. The latch holds an enable flag, a bus number, a device/function index and a dword register index. A data-window access is forwarded only when the latch is enabled and names bus zero.

The device/function index is resolved through a 256-entry lookup map. A registration port fills the map, handing out target slots in ascending order. Reads that cannot be routed return all-ones. Writes to the standard header identity and status offsets are dropped before they reach a target. A data shadow register keeps the last value that passed through the data window. The read path is combinational, so a read result is valid in the same cycle as the request.

Top module: `cfg_port_router`

## Requirements
- R1: A 4-byte write to I/O address 0x0CF8 loads the 32-bit latch on that clock edge. A read of 0x0CF8 returns the latch value in the same cycle. Reset clears the latch to zero.
- R2: Any access whose address is neither 0x0CF8 nor 0x0CFC to 0x0CFF, and any latch access whose length is not 4, sets `io_err` high on the next edge for exactly one cycle. Such an access leaves the latch unchanged.
- R3: A data-window access reaches a target only when latch bit 31 is 1 and latch bits 23:16 are all zero.
- R4: The map is indexed by latch bits 15:8. `tgt_off` is latch bits 7:2 followed by address bits 1:0. `tgt_len` and `tgt_wdata` pass `io_len` and `io_wdata` through unchanged. A routed read returns the selected target's data in the same cycle.
- R5: A data-window read returns 0xFFFFFFFF and selects no target when any of these holds: the R3 test fails, the map entry is unassigned, or the length is not 1, 2 or 4. Any write cycle also returns 0xFFFFFFFF.
- R6: A routed write is forwarded (`tgt_wr`=1 plus one select bit) only for register offsets 4 to 7, 12, 13 and 15 to 255. Writes to any other offset drive no select bit.
- R7: After reset every map entry holds the unassigned code, which equals `NSLOT`. Accepted registrations receive slots 0, 1, 2 and so on in order. `reg_slot` shows the slot being granted.
- R8: Registering a device/function that is already mapped is refused (`reg_accept`=0, `reg_full`=0) and uses up no slot.
- R9: Registering an unmapped device/function after all `NSLOT` slots are used is refused, with `reg_full`=1 in that cycle.
- R10: `cfg_data_shadow` resets to zero. On every data-window read it takes the value returned. On every forwarded write it takes `io_wdata` shifted left by 8 times address bits 1:0. Dropped writes leave it unchanged.
- R11: `tgt_sel` has at most one bit set, and only while a valid data-window access is being routed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| io_valid | input | 1 | I/O request strobe |
| io_write | input | 1 | 1 = write, 0 = read |
| io_addr | input | 16 | I/O port address |
| io_len | input | 3 | Access length in bytes |
| io_wdata | input | 32 | Write data |
| io_rdata | output | 32 | Same-cycle read data |
| io_err | output | 1 | One-cycle unsupported-access pulse |
| cfg_data_shadow | output | 32 | Last value seen on the data window |
| reg_valid | input | 1 | Registration request |
| reg_devfn | input | 8 | Device/function to register |
| reg_accept | output | 1 | Registration granted this cycle |
| reg_slot | output | SLOT_W | Slot being granted |
| reg_full | output | 1 | Registration refused because all slots are used |
| tgt_sel | output | NSLOT | One-hot target select |
| tgt_wr | output | 1 | Forwarded write strobe |
| tgt_off | output | 8 | Register offset to target |
| tgt_len | output | 3 | Length to target |
| tgt_wdata | output | 32 | Write data to target |
| tgt_rdata | input | NSLOT*32 | Per-slot read data, slot 0 in the low lanes |

## Verification
The assertions assume a single request per cycle, with `io_len` stable while `io_valid` is high. They also assume a target's read data depends only on the offset it is given, so that a routed read has a settled answer in the same cycle. The bench drives every request on the falling edge, holds it for one full cycle and drops `io_valid` afterwards. Its target models are pure functions of `tgt_off` and the slot number. Registration is never issued in the same cycle as a data access, so the map never changes under a lookup.

// File: rtl/cfg_router_pkg.sv
package cfg_router_pkg;

  localparam logic [15:0] LATCH_PORT  = 16'h0CF8;
  localparam logic [13:0] WINDOW_DW   = 14'h033F;   // 0x0CFC >> 2
  localparam int          DEVFN_W     = 8;
  localparam int          MAP_DEPTH   = 1 << DEVFN_W;

  typedef enum logic [1:0] {
    PK_NONE   = 2'd0,
    PK_LATCH  = 2'd1,
    PK_WINDOW = 2'd2
  } port_kind_e;

  // offsets a host may write through the window
  function automatic logic offset_writable(input logic [7:0] off);
    return ((off >= 8'd4) && (off <= 8'd7)) || (off == 8'd12) ||
           (off == 8'd13) || (off > 8'd14);
  endfunction

endpackage

// File: rtl/cfg_addr_latch.sv
module cfg_addr_latch (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        ld_en,
  input  logic [31:0] ld_data,
  output logic [31:0] latch_q,
  output logic        route_ok,
  output logic [7:0]  devfn,
  output logic [5:0]  dw_idx
);

  logic [31:0] latch_d;

  always_comb begin
    latch_d = latch_q;
    if (ld_en) latch_d = ld_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) latch_q <= '0;
    else        latch_q <= latch_d;
  end

  assign route_ok = latch_q[31] && (latch_q[23:16] == 8'h00);
  assign devfn    = latch_q[15:8];
  assign dw_idx   = latch_q[7:2];

  assert_latch_load_R1: assert property (@(posedge clk) disable iff (!rst_n)
    ld_en |=> (latch_q == $past(ld_data)));

  assert_latch_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !ld_en |=> $stable(latch_q));

endmodule

// File: rtl/cfg_devfn_map.sv
module cfg_devfn_map
  import cfg_router_pkg::*;
#(
  parameter int NSLOT  = 4,
  parameter int SLOT_W = $clog2(NSLOT + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [7:0]        lk_devfn,
  output logic [SLOT_W-1:0] lk_slot,
  output logic              lk_hit,
  input  logic              reg_valid,
  input  logic [7:0]        reg_devfn,
  output logic              reg_accept,
  output logic [SLOT_W-1:0] reg_slot,
  output logic              reg_full
);

  localparam logic [SLOT_W-1:0] UNASSIGNED = SLOT_W'(NSLOT);

  logic [SLOT_W-1:0] map_q [MAP_DEPTH];
  logic [SLOT_W-1:0] cnt_q, cnt_d;
  logic              free_entry;

  assign free_entry = (map_q[reg_devfn] == UNASSIGNED);
  assign reg_accept = reg_valid && free_entry && (cnt_q < UNASSIGNED);
  assign reg_full   = reg_valid && free_entry && (cnt_q == UNASSIGNED);
  assign reg_slot   = cnt_q;

  always_comb begin
    cnt_d = cnt_q;
    if (reg_accept) cnt_d = cnt_q + SLOT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < MAP_DEPTH; i++) map_q[i] <= UNASSIGNED;
    end else if (reg_accept) begin
      map_q[reg_devfn] <= cnt_q;
    end
  end

  assign lk_slot = map_q[lk_devfn];
  assign lk_hit  = (lk_slot != UNASSIGNED);

  assert_slot_bound_R7: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= UNASSIGNED);

  assert_slot_order_R7: assert property (@(posedge clk) disable iff (!rst_n)
    reg_accept |=> (cnt_q == $past(cnt_q) + SLOT_W'(1)));

  assert_full_refused_R9: assert property (@(posedge clk) disable iff (!rst_n)
    reg_full |=> $stable(cnt_q));

  assert_no_double_grant_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !(reg_accept && reg_full));

endmodule

// File: rtl/cfg_port_router.sv
module cfg_port_router
  import cfg_router_pkg::*;
#(
  parameter int NSLOT  = 4,
  parameter int SLOT_W = $clog2(NSLOT + 1)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                io_valid,
  input  logic                io_write,
  input  logic [15:0]         io_addr,
  input  logic [2:0]          io_len,
  input  logic [31:0]         io_wdata,
  output logic [31:0]         io_rdata,
  output logic                io_err,
  output logic [31:0]         cfg_data_shadow,
  input  logic                reg_valid,
  input  logic [7:0]          reg_devfn,
  output logic                reg_accept,
  output logic [SLOT_W-1:0]   reg_slot,
  output logic                reg_full,
  output logic [NSLOT-1:0]    tgt_sel,
  output logic                tgt_wr,
  output logic [7:0]          tgt_off,
  output logic [2:0]          tgt_len,
  output logic [31:0]         tgt_wdata,
  input  logic [NSLOT*32-1:0] tgt_rdata
);

  // reset: asserted asynchronously, released on a clock edge
  logic rst_meta_q, rst_sync_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_n <= rst_meta_q;
    end
  end

  // port decode
  port_kind_e kind;
  always_comb begin
    if (io_addr == LATCH_PORT)          kind = PK_LATCH;
    else if (io_addr[15:2] == WINDOW_DW) kind = PK_WINDOW;
    else                                 kind = PK_NONE;
  end

  logic len_is4, len_ok, latch_ld, bad_acc;
  assign len_is4  = (io_len == 3'd4);
  assign len_ok   = (io_len == 3'd1) || (io_len == 3'd2) || len_is4;
  assign latch_ld = io_valid && io_write && (kind == PK_LATCH) && len_is4;
  assign bad_acc  = io_valid && ((kind == PK_NONE) || ((kind == PK_LATCH) && !len_is4));

  logic [31:0] latch_q;
  logic        route_ok;
  logic [7:0]  devfn;
  logic [5:0]  dw_idx;

  cfg_addr_latch u_latch (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .ld_en    (latch_ld),
    .ld_data  (io_wdata),
    .latch_q  (latch_q),
    .route_ok (route_ok),
    .devfn    (devfn),
    .dw_idx   (dw_idx)
  );

  logic [SLOT_W-1:0] lk_slot;
  logic              lk_hit;

  cfg_devfn_map #(.NSLOT(NSLOT), .SLOT_W(SLOT_W)) u_map (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .lk_devfn   (devfn),
    .lk_slot    (lk_slot),
    .lk_hit     (lk_hit),
    .reg_valid  (reg_valid),
    .reg_devfn  (reg_devfn),
    .reg_accept (reg_accept),
    .reg_slot   (reg_slot),
    .reg_full   (reg_full)
  );

  // routing
  logic       win_acc, routed, fwd_rd, fwd_wr, fwd_any;
  logic [7:0] off;
  assign win_acc = io_valid && (kind == PK_WINDOW);
  assign routed  = win_acc && route_ok && lk_hit && len_ok;
  assign off     = {dw_idx, io_addr[1:0]};
  assign fwd_rd  = routed && !io_write;
  assign fwd_wr  = routed && io_write && offset_writable(off);
  assign fwd_any = fwd_rd || fwd_wr;

  for (genvar g = 0; g < NSLOT; g++) begin : g_sel
    assign tgt_sel[g] = fwd_any && (lk_slot == SLOT_W'(g));
  end

  assign tgt_wr    = fwd_wr;
  assign tgt_off   = off;
  assign tgt_len   = io_len;
  assign tgt_wdata = io_wdata;

  logic [31:0] rd_mux;
  always_comb begin
    rd_mux = '0;
    for (int i = 0; i < NSLOT; i++)
      if (tgt_sel[i]) rd_mux = tgt_rdata[i*32 +: 32];
  end

  always_comb begin
    if (io_valid && !io_write && (kind == PK_LATCH)) io_rdata = latch_q;
    else if (fwd_rd)                                  io_rdata = rd_mux;
    else                                              io_rdata = '1;
  end

  // data shadow and error pulse
  logic [31:0] shadow_d;
  logic        err_d;
  always_comb begin
    shadow_d = cfg_data_shadow;
    if (win_acc && !io_write) shadow_d = io_rdata;
    else if (fwd_wr)          shadow_d = io_wdata << {io_addr[1:0], 3'b000};
    err_d = bad_acc;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      cfg_data_shadow <= '0;
      io_err          <= 1'b0;
    end else begin
      cfg_data_shadow <= shadow_d;
      io_err          <= err_d;
    end
  end

  assert_sel_onehot_R11: assert property (@(posedge clk) disable iff (!rst_sync_n)
    $onehot0(tgt_sel));

  assert_sel_needs_req_R11: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (tgt_sel != '0) |-> (io_valid && io_addr[15:2] == WINDOW_DW));

  assert_route_gate_R3: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (tgt_sel != '0) |-> (latch_q[31] && latch_q[23:16] == 8'h00));

  assert_write_filter_R6: assert property (@(posedge clk) disable iff (!rst_sync_n)
    tgt_wr |-> !(tgt_off inside {[8'd0:8'd3], [8'd8:8'd11], 8'd14}));

  assert_miss_ones_R5: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (io_valid && !io_write && io_addr[15:2] == WINDOW_DW && tgt_sel == '0)
      |-> (io_rdata == 32'hFFFF_FFFF));

  assert_err_cause_R2: assert property (@(posedge clk) disable iff (!rst_sync_n)
    io_err |-> $past(io_valid));

endmodule

// File: tb/cfg_port_router_tb_top.sv
`timescale 1ns/1ps
module cfg_port_router_tb_top;

  localparam int NSLOT  = 4;
  localparam int SLOT_W = $clog2(NSLOT + 1);

  logic                clk = 1'b0;
  logic                rst_n;
  logic                io_valid, io_write;
  logic [15:0]         io_addr;
  logic [2:0]          io_len;
  logic [31:0]         io_wdata, io_rdata, cfg_data_shadow;
  logic                io_err;
  logic                reg_valid;
  logic [7:0]          reg_devfn;
  logic                reg_accept, reg_full;
  logic [SLOT_W-1:0]   reg_slot;
  logic [NSLOT-1:0]    tgt_sel;
  logic                tgt_wr;
  logic [7:0]          tgt_off;
  logic [2:0]          tgt_len;
  logic [31:0]         tgt_wdata;
  logic [NSLOT*32-1:0] tgt_rdata;

  always #2 clk = ~clk;   // 250 MHz

  // target models: slot s answers {0xA0+s, 0x0000, offset}
  for (genvar s = 0; s < NSLOT; s++) begin : g_tgt
    assign tgt_rdata[s*32 +: 32] = {8'hA0 + 8'(s), 16'h0000, tgt_off};
  end

  cfg_port_router #(.NSLOT(NSLOT)) dut_i (
    .clk(clk), .rst_n(rst_n),
    .io_valid(io_valid), .io_write(io_write), .io_addr(io_addr),
    .io_len(io_len), .io_wdata(io_wdata), .io_rdata(io_rdata),
    .io_err(io_err), .cfg_data_shadow(cfg_data_shadow),
    .reg_valid(reg_valid), .reg_devfn(reg_devfn), .reg_accept(reg_accept),
    .reg_slot(reg_slot), .reg_full(reg_full),
    .tgt_sel(tgt_sel), .tgt_wr(tgt_wr), .tgt_off(tgt_off),
    .tgt_len(tgt_len), .tgt_wdata(tgt_wdata), .tgt_rdata(tgt_rdata)
  );

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 0;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
    end
  endtask

  // sampled during an access
  logic [31:0]      s_rdata;
  logic [NSLOT-1:0] s_sel;
  logic             s_wr;
  logic [7:0]       s_off;
  logic [2:0]       s_len;
  logic [31:0]      s_wdata;

  task automatic io_op(input logic wr, input logic [15:0] a, input logic [2:0] l,
                       input logic [31:0] d);
    @(negedge clk);
    io_valid = 1'b1; io_write = wr; io_addr = a; io_len = l; io_wdata = d;
    #1;
    s_rdata = io_rdata; s_sel = tgt_sel; s_wr = tgt_wr; s_off = tgt_off;
    s_len = tgt_len; s_wdata = tgt_wdata;
    @(posedge clk); #1;
    io_valid = 1'b0; io_write = 1'b0;
  endtask

  logic s_acc, s_full;
  logic [SLOT_W-1:0] s_slot;
  task automatic reg_op(input logic [7:0] df);
    @(negedge clk);
    reg_valid = 1'b1; reg_devfn = df;
    #1;
    s_acc = reg_accept; s_full = reg_full; s_slot = reg_slot;
    @(posedge clk); #1;
    reg_valid = 1'b0;
  endtask

  // vector: {latch, port[1:0], len, wr, wdata, exp_sel, exp_rdata}
  localparam int NV = 14;
  localparam logic [105:0] VEC [NV] = '{
    {32'h80000000, 2'd0, 3'd4, 1'b0, 32'h00000000, 4'b0001, 32'hA0000000},
    {32'h80000810, 2'd2, 3'd1, 1'b0, 32'h00000000, 4'b0010, 32'hA1000012},
    {32'h80001104, 2'd3, 3'd2, 1'b0, 32'h00000000, 4'b0100, 32'hA2000007},
    {32'h00000800, 2'd0, 3'd4, 1'b0, 32'h00000000, 4'b0000, 32'hFFFFFFFF},
    {32'h80010800, 2'd0, 3'd4, 1'b0, 32'h00000000, 4'b0000, 32'hFFFFFFFF},
    {32'h80002000, 2'd0, 3'd4, 1'b0, 32'h00000000, 4'b0000, 32'hFFFFFFFF},
    {32'h80000800, 2'd0, 3'd5, 1'b0, 32'h00000000, 4'b0000, 32'hFFFFFFFF},
    {32'h80000804, 2'd0, 3'd4, 1'b1, 32'h11223344, 4'b0010, 32'hFFFFFFFF},
    {32'h80000800, 2'd2, 3'd2, 1'b1, 32'h0000BEEF, 4'b0000, 32'hFFFFFFFF},
    {32'h8000080C, 2'd1, 3'd1, 1'b1, 32'h000000AB, 4'b0010, 32'hFFFFFFFF},
    {32'h8000080C, 2'd2, 3'd1, 1'b1, 32'h000000CD, 4'b0000, 32'hFFFFFFFF},
    {32'h8000080C, 2'd3, 3'd1, 1'b1, 32'h0000005A, 4'b0010, 32'hFFFFFFFF},
    {32'h80000808, 2'd0, 3'd4, 1'b1, 32'h00000077, 4'b0000, 32'hFFFFFFFF},
    {32'h00000804, 2'd0, 3'd4, 1'b1, 32'h00000099, 4'b0000, 32'hFFFFFFFF}
  };

  initial begin
    #(4 * 150000);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] shadow_m;
    rst_n = 1'b0; io_valid = 1'b0; io_write = 1'b0; io_addr = '0; io_len = '0;
    io_wdata = '0; reg_valid = 1'b0; reg_devfn = '0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    repeat (4) @(posedge clk);
    #1;

    // reset state
    chk("R10 shadow after reset", cfg_data_shadow, 32'h0);
    chk("R2 err after reset", {31'b0, io_err}, 32'h0);
    chk("R11 sel idle", {28'b0, tgt_sel}, 32'h0);
    io_op(1'b0, 16'h0CF8, 3'd4, 32'h0);
    chk("R1 latch reset value", s_rdata, 32'h0);

    // registration in order
    reg_op(8'h00);
    chk("R7 first slot", {31'b0, s_acc}, 32'h1);
    chk("R7 first slot number", 32'(s_slot), 32'd0);
    reg_op(8'h08);
    chk("R7 second slot number", 32'(s_slot), 32'd1);
    reg_op(8'h11);
    chk("R7 third slot number", 32'(s_slot), 32'd2);
    reg_op(8'h08);
    chk("R8 duplicate refused", {30'b0, s_acc, s_full}, 32'h0);

    // unassigned entry misses
    io_op(1'b1, 16'h0CF8, 3'd4, 32'h80003000);
    io_op(1'b0, 16'h0CFC, 3'd4, 32'h0);
    chk("R7 unassigned entry reads ones", s_rdata, 32'hFFFFFFFF);
    chk("R5 unassigned no select", {28'b0, s_sel}, 32'h0);
    shadow_m = 32'hFFFFFFFF;

    // vector table
    for (int v = 0; v < NV; v++) begin
      logic [31:0] lat, wd, er;
      logic [1:0]  pt;
      logic [2:0]  ln;
      logic        w;
      logic [3:0]  es;
      {lat, pt, ln, w, wd, es, er} = VEC[v];
      io_op(1'b1, 16'h0CF8, 3'd4, lat);
      io_op(w, {14'h033F, pt}, ln, wd);
      chk(w ? "R6 write select" : "R3 read select", {28'b0, s_sel}, {28'b0, es});
      chk(w ? "R5 write cycle data" : "R4 read data", s_rdata, er);
      chk("R6 write strobe", {31'b0, s_wr}, {31'b0, w && (es != 4'b0)});
      if (es != 4'b0) begin
        chk("R4 offset", {24'b0, s_off}, {24'b0, lat[7:2], pt});
        chk("R4 length", {29'b0, s_len}, {29'b0, ln});
        chk("R4 wdata", s_wdata, wd);
      end
      if (!w)             shadow_m = er;
      else if (es != 4'b0) shadow_m = wd << (8 * pt);
      chk("R10 shadow", cfg_data_shadow, shadow_m);
    end

    // fill last slot, then full
    reg_op(8'h30);
    chk("R7 fourth slot number", 32'(s_slot), 32'd3);
    reg_op(8'h40);
    chk("R9 full refused", {30'b0, s_acc, s_full}, 32'h1);
    io_op(1'b1, 16'h0CF8, 3'd4, 32'h80003008);
    io_op(1'b0, 16'h0CFC, 3'd4, 32'h0);
    chk("R4 last slot read", s_rdata, 32'hA3000008);
    io_op(1'b1, 16'h0CF8, 3'd4, 32'h80004000);
    io_op(1'b0, 16'h0CFC, 3'd4, 32'h0);
    chk("R9 refused entry stays unmapped", s_rdata, 32'hFFFFFFFF);

    // latch read back, bad accesses
    io_op(1'b1, 16'h0CF8, 3'd4, 32'h8000_1234);
    io_op(1'b0, 16'h0CF8, 3'd4, 32'h0);
    chk("R1 latch read back", s_rdata, 32'h80001234);
    chk("R2 no err on good access", {31'b0, io_err}, 32'h0);
    io_op(1'b1, 16'h0CF8, 3'd2, 32'h0000_5555);
    chk("R2 err on short latch write", {31'b0, io_err}, 32'h1);
    io_op(1'b0, 16'h0CF8, 3'd4, 32'h0);
    chk("R2 err clears", {31'b0, io_err}, 32'h0);
    chk("R2 latch unchanged", s_rdata, 32'h80001234);
    io_op(1'b1, 16'h0080, 3'd1, 32'h0);
    chk("R2 err on other port", {31'b0, io_err}, 32'h1);
    @(posedge clk); #1;
    chk("R2 err one cycle", {31'b0, io_err}, 32'h0);

    finished = 1;
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

endmodule